// File: doc/BRIEF.md
# Table-Driven Spike Event Fan-Out Router

This block takes one incoming spike event at a time, each carrying the address of the neuron that fired, and turns it into a series of synapse records. The list of targets for every source neuron sits in an external synchronous memory. The block forms the memory line index from the source address and a running offset. It then walks consecutive lines, emitting one record per line, until it reads a terminator line. No connection pattern is built into the logic, so rewriting the memory changes the network.

Each memory line holds one connection. The fields are the target address, a weight magnitude, an event-count multiplier, a firing probability and a reversal (equilibrium) potential. A small band of reserved target addresses at the top of the target range means "activate a group of cells". Such records are passed on with a group flag set. Input and output both use valid/ready handshakes. The block keeps a single memory read in flight, and while the consumer holds ready low it freezes its output record.

Top module: `evt_fanout_router`

## Requirements
- R1: After reset the block shows in_ready=1, out_valid=0, mem_rd_en=0 and ovf_flag=0.
- R2: When an event is accepted (in_valid and in_ready both high at a clock edge), mem_rd_en is high in that cycle and mem_addr equals {in_src, OFS_W zero bits}. Each later read of the same list uses the same upper bits and an offset one higher than the previous read.
- R3: The memory line is laid out, from MSB to LSB, as target (DST_W), weight (WGT_W), multiplier (CNT_W), probability (PRB_W), potential (POT_W). Each emitted record carries these fields unchanged from its line, and records leave in offset order.
- R4: A line with every bit set is a terminator. It produces no record, it ends the list, and the list issues no further read.
- R5: A record whose target lies in the top NUM_BCAST codes of the target range (target >= 2^DST_W - NUM_BCAST) has out_bcast=1. Every other record has out_bcast=0.
- R6: While out_valid=1 and out_ready=0, the record holds stable and no memory read is issued.
- R7: in_ready stays low from the accept of an event until its list has ended. This covers a terminator that has been read, or the last record handed off.
- R8: If the line at the largest offset (2^OFS_W - 1) is not a terminator, it is emitted, the list ends with no further read, and ovf_flag rises. ovf_flag then stays high until reset. A list that terminates at the largest offset leaves ovf_flag low.
- R9: A list whose first line is a terminator produces no record, and the block returns to accepting events.
- R10: Read data is taken one cycle after mem_rd_en, and mem_rd_en is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming event valid |
| in_ready | output | 1 | Block can accept an event |
| in_src | input | SRC_W | Source neuron address of the event |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | SRC_W+OFS_W | Memory line index {source, offset} |
| mem_rd_data | input | DST_W+WGT_W+CNT_W+PRB_W+POT_W | Line data, one cycle after the strobe |
| out_valid | output | 1 | Synapse record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_dst | output | DST_W | Target address |
| out_weight | output | WGT_W | Weight magnitude |
| out_mult | output | CNT_W | Events per incoming event |
| out_prob | output | PRB_W | Firing probability |
| out_pot | output | POT_W | Equilibrium potential |
| out_bcast | output | 1 | Target is a group-activation code |
| ovf_flag | output | 1 | Sticky: a list ran past the last offset |

## Verification
The bench builds the block with SRC_W=3, OFS_W=8, DST_W=8 and NUM_BCAST=4. With only eight sources, every source can be given a list computed by formula. The full 8-bit offset makes the 256-line overrun list and the 255-entry list ending at the last offset both reachable, and together they separate an overflow from a legal full list. The four group codes sit where ordinary computed targets fall into them, and a constant stall pattern on out_ready exercises holding the record across every state.

// File: rtl/evr_pkg.sv
package evr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_EMIT = 2'd2
   } evr_state_e;
endpackage

// File: rtl/evr_line_decode.sv
module evr_line_decode #(
   parameter int DST_W     = 8,
   parameter int WGT_W     = 4,
   parameter int CNT_W     = 4,
   parameter int PRB_W     = 8,
   parameter int POT_W     = 8,
   parameter int NUM_BCAST = 4,
   localparam int LINE_W   = DST_W + WGT_W + CNT_W + PRB_W + POT_W
) (
   input  logic [LINE_W-1:0] line,
   output logic [DST_W-1:0]  dst,
   output logic [WGT_W-1:0]  wgt,
   output logic [CNT_W-1:0]  cnt,
   output logic [PRB_W-1:0]  prb,
   output logic [POT_W-1:0]  pot,
   output logic              is_stop,
   output logic              is_bcast
);
   assign {dst, wgt, cnt, prb, pot} = line;
   assign is_stop = &line;

   generate
      if (NUM_BCAST == 0) begin : g_no_bcast
         assign is_bcast = 1'b0;
      end else begin : g_bcast
         localparam logic [DST_W-1:0] BC_LO = {DST_W{1'b1}} - DST_W'(NUM_BCAST - 1);
         assign is_bcast = (dst >= BC_LO);
      end
   endgenerate
endmodule

// File: rtl/evr_offset_ctr.sv
module evr_offset_ctr #(
   parameter int OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [OFS_W-1:0] ofs,
   output logic [OFS_W-1:0] ofs_next,
   output logic             at_max
);
   assign ofs_next = ofs + OFS_W'(1);
   assign at_max   = &ofs;

   always_ff @(posedge clk) begin
      if (!rst_n)   ofs <= '0;
      else if (clr) ofs <= '0;
      else if (inc) ofs <= ofs_next;
   end
endmodule

// File: rtl/evr_out_reg.sv
module evr_out_reg #(
   parameter int W = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_fanout_router.sv
module evt_fanout_router #(
   parameter int SRC_W     = 8,
   parameter int OFS_W     = 8,
   parameter int DST_W     = 8,
   parameter int WGT_W     = 4,
   parameter int CNT_W     = 4,
   parameter int PRB_W     = 8,
   parameter int POT_W     = 8,
   parameter int NUM_BCAST = 4,
   localparam int ADDR_W   = SRC_W + OFS_W,
   localparam int LINE_W   = DST_W + WGT_W + CNT_W + PRB_W + POT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SRC_W-1:0]  in_src,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [LINE_W-1:0] mem_rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DST_W-1:0]  out_dst,
   output logic [WGT_W-1:0]  out_weight,
   output logic [CNT_W-1:0]  out_mult,
   output logic [PRB_W-1:0]  out_prob,
   output logic [POT_W-1:0]  out_pot,
   output logic              out_bcast,
   output logic              ovf_flag
);
   import evr_pkg::*;

   localparam int REC_W = LINE_W + 1;

   generate
      if (SRC_W < 1 || OFS_W < 1) begin : g_bad_addr
         $error("evt_fanout_router: SRC_W and OFS_W must be at least 1");
      end
      if (DST_W < 2 || DST_W > 30) begin : g_bad_dst
         $error("evt_fanout_router: DST_W must lie in 2..30");
      end
      if (NUM_BCAST < 0 || NUM_BCAST >= (1 << DST_W) - 1) begin : g_bad_bc
         $error("evt_fanout_router: NUM_BCAST out of range");
      end
   endgenerate

   evr_state_e        state;
   logic [SRC_W-1:0]  src_q;
   logic              accept;
   logic              out_hs;
   logic              ctr_clr;
   logic              ctr_inc;
   logic [OFS_W-1:0]  ofs;
   logic [OFS_W-1:0]  ofs_next;
   logic              ofs_at_max;

   logic [DST_W-1:0]  ln_dst;
   logic [WGT_W-1:0]  ln_wgt;
   logic [CNT_W-1:0]  ln_cnt;
   logic [PRB_W-1:0]  ln_prb;
   logic [POT_W-1:0]  ln_pot;
   logic              ln_stop;
   logic              ln_bcast;

   logic              rec_load;
   logic [REC_W-1:0]  rec_in;
   logic [REC_W-1:0]  rec_q;

   evr_line_decode #(
      .DST_W(DST_W), .WGT_W(WGT_W), .CNT_W(CNT_W),
      .PRB_W(PRB_W), .POT_W(POT_W), .NUM_BCAST(NUM_BCAST)
   ) u_dec (
      .line     (mem_rd_data),
      .dst      (ln_dst),
      .wgt      (ln_wgt),
      .cnt      (ln_cnt),
      .prb      (ln_prb),
      .pot      (ln_pot),
      .is_stop  (ln_stop),
      .is_bcast (ln_bcast)
   );

   evr_offset_ctr #(.OFS_W(OFS_W)) u_ofs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctr_clr),
      .inc      (ctr_inc),
      .ofs      (ofs),
      .ofs_next (ofs_next),
      .at_max   (ofs_at_max)
   );

   evr_out_reg #(.W(REC_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rec_load),
      .din   (rec_in),
      .ready (out_ready),
      .valid (out_valid),
      .dout  (rec_q)
   );

   // Handshakes and control strobes
   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign out_hs   = (state == ST_EMIT) && out_valid && out_ready;
   assign ctr_clr  = accept;
   assign ctr_inc  = out_hs && !ofs_at_max;
   assign rec_load = (state == ST_WAIT) && !ln_stop;
   assign rec_in   = {ln_dst, ln_wgt, ln_cnt, ln_prb, ln_pot, ln_bcast};

   // One read in flight: issue on accept, or after each handoff while the list continues
   assign mem_rd_en = accept || ctr_inc;
   assign mem_addr  = accept ? {in_src, {OFS_W{1'b0}}} : {src_q, ofs_next};

   assign {out_dst, out_weight, out_mult, out_prob, out_pot, out_bcast} = rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         src_q    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  src_q <= in_src;
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ln_stop) begin
                  state <= ST_IDLE;
               end else begin
                  state <= ST_EMIT;
                  if (ofs_at_max) ovf_flag <= 1'b1;
               end
            end
            ST_EMIT: begin
               if (out_hs) state <= ofs_at_max ? ST_IDLE : ST_WAIT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
   parameter int SRC_W  = 8,
   parameter int OFS_W  = 8,
   parameter int LINE_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic [SRC_W-1:0]       in_src,
   input logic                   mem_rd_en,
   input logic [SRC_W+OFS_W-1:0] mem_addr,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [LINE_W-1:0]      out_line,
   input logic                   out_bcast,
   input logic                   ovf_flag
);
   // R2: accepted event starts its list at offset zero of its own source
   a_r2_list_base: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (mem_rd_en && mem_addr == {in_src, {OFS_W{1'b0}}}));

   // R4: a terminator line never reaches the output
   a_r4_no_stop_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(&out_line));

   // R6: stalled record is frozen
   a_r6_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_line) && $stable(out_bcast)));

   // R6: no read while stalled
   a_r6_no_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !mem_rd_en);

   // R7: no accept while a record is pending
   a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R8: overflow flag is sticky
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   // R10: single outstanding read
   a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);
endmodule

bind evt_fanout_router evr_checker #(
   .SRC_W(SRC_W), .OFS_W(OFS_W), .LINE_W(LINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_src    (in_src),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_line  ({out_dst, out_weight, out_mult, out_prob, out_pot}),
   .out_bcast (out_bcast),
   .ovf_flag  (ovf_flag)
);

// File: tb/sim_evt_fanout_router.sv
module sim_evt_fanout_router;
   localparam int CLK_PERIOD = 10;
   localparam int SRC_W  = 3;
   localparam int OFS_W  = 8;
   localparam int DST_W  = 8;
   localparam int LINE_W = 32;
   localparam int NSRC   = 1 << SRC_W;
   localparam int NLINE  = 1 << (SRC_W + OFS_W);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [SRC_W-1:0] in_src = '0;
   logic mem_rd_en;
   logic [SRC_W+OFS_W-1:0] mem_addr;
   logic [LINE_W-1:0] mem_rd_data;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [7:0] out_dst;
   logic [3:0] out_weight;
   logic [3:0] out_mult;
   logic [7:0] out_prob;
   logic [7:0] out_pot;
   logic out_bcast;
   logic ovf_flag;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   int list_len [NSRC] = '{0, 3, 1, 5, 255, 7, 2, 256};
   logic [LINE_W-1:0] ram [NLINE];
   logic [LINE_W:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_fanout_router #(
      .SRC_W(SRC_W), .OFS_W(OFS_W), .DST_W(DST_W), .WGT_W(4), .CNT_W(4),
      .PRB_W(8), .POT_W(8), .NUM_BCAST(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_src(in_src), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_dst(out_dst), .out_weight(out_weight), .out_mult(out_mult),
      .out_prob(out_prob), .out_pot(out_pot), .out_bcast(out_bcast),
      .ovf_flag(ovf_flag)
   );

   // Behavioural synchronous memory, one cycle latency
   always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= ram[mem_addr];

   function automatic logic [LINE_W-1:0] line_of(int s, int k);
      logic [7:0] d;
      if (k < list_len[s]) begin
         d = 8'((s * 37 + k * 11) & 255);
         if (s == 1 && k == 1) d = 8'hFE;
         if (s == 2 && k == 0) d = 8'hFF;
         return {d, 4'(k), 4'(s + k), {1'b0, 7'((k * 3) & 127)}, 8'(k ^ 8'h5A)};
      end else if (k == list_len[s]) begin
         return '1;
      end else begin
         return 32'h1234_5678 ^ 32'(k);
      end
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Consumer stall pattern
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         #1;
         out_ready = ((cyc % 5) != 3) && ((cyc % 7) != 0);
         cyc++;
      end
   end

   // Monitor
   int cur_src = 0;
   int rd_cnt = 0;
   int rd_exp = 0;
   bit prev_rd = 1'b0;
   bit held_v = 1'b0;
   logic [LINE_W:0] held;

   always @(negedge clk) begin
      logic [LINE_W:0] rec;
      rec = {out_dst, out_weight, out_mult, out_prob, out_pot, out_bcast};
      if (rst_n) begin
         if (in_valid && in_ready) begin
            // R7: previous list fully drained before a new accept
            chk(exp_q.size() == 0 && rd_cnt == rd_exp, "R7", "accept while busy",
                exp_q.size(), 0);
            cur_src = int'(in_src);
            rd_cnt = 0;
            rd_exp = (list_len[cur_src] < 256) ? list_len[cur_src] + 1 : 256;
            for (int k = 0; k < list_len[cur_src]; k++) begin
               logic [LINE_W-1:0] l;
               l = line_of(cur_src, k);
               exp_q.push_back({l, (l[31:24] >= 8'hFC)});
            end
         end
         if (mem_rd_en) begin
            // R2 / R4: read address and no read past the terminator
            chk(rd_cnt < rd_exp, "R4", "read past list end", rd_cnt, rd_exp);
            chk(mem_addr == {3'(cur_src), 8'(rd_cnt)}, "R2", "read address",
                mem_addr, {3'(cur_src), 8'(rd_cnt)});
            rd_cnt++;
         end
         // R10: never two reads back to back
         if (prev_rd && mem_rd_en) chk(1'b0, "R10", "back-to-back read", 1, 0);
         prev_rd = mem_rd_en;
         if (held_v) begin
            chk(out_valid && rec == held, "R6", "stalled record changed", rec, held);
            held_v = 1'b0;
         end
         if (out_valid) begin
            if (out_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3", "unexpected record", rec, 0);
               end else begin
                  logic [LINE_W:0] e;
                  e = exp_q.pop_front();
                  chk(rec[LINE_W:1] == e[LINE_W:1], "R3", "record fields", rec, e);
                  chk(rec[0] == e[0], "R5", "group flag", rec[0], e[0]);
               end
            end else begin
               chk(!mem_rd_en, "R6", "read during stall", mem_rd_en, 0);
               held = rec;
               held_v = 1'b1;
            end
         end
      end
   end

   task automatic send(int s);
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_src = 3'(s);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(in_ready && exp_q.size() == 0 && !out_valid));
      repeat (2) @(negedge clk);
      chk(rd_cnt == rd_exp, "R4", "reads for list", rd_cnt, rd_exp);
   endtask

   initial begin
      for (int a = 0; a < NLINE; a++) ram[a] = line_of(a >> OFS_W, a & 255);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
      chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
      chk(mem_rd_en == 1'b0, "R1", "mem_rd_en", mem_rd_en, 0);
      chk(ovf_flag == 1'b0, "R1", "ovf_flag", ovf_flag, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: empty list first, then short lists back to back
      send(0);
      wait_idle();
      chk(in_ready == 1'b1, "R9", "ready after empty list", in_ready, 1);
      send(1); send(2); send(3);
      wait_idle();
      // full list terminated at the last offset: no overflow
      send(4);
      wait_idle();
      chk(ovf_flag == 1'b0, "R8", "no overflow on legal full list", ovf_flag, 0);
      send(5); send(6);
      wait_idle();
      // R8: list without terminator
      send(7);
      wait_idle();
      chk(ovf_flag == 1'b1, "R8", "overflow raised", ovf_flag, 1);
      send(1);
      wait_idle();
      chk(ovf_flag == 1'b1, "R8", "overflow sticky", ovf_flag, 1);
      chk(exp_q.size() == 0, "R3", "records outstanding", exp_q.size(), 0);
      summary();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      summary();
   end
endmodule